// File: doc/BRIEF.md
# Ethernet Header Prepend Streamer

This block builds an outgoing Ethernet byte stream from two independent inputs. A header port hands over the destination MAC address, source MAC address and EtherType together in one valid/ready transfer. A payload port delivers the frame body as an AXI4-Stream-style byte stream. The block emits the 14 header bytes first and then passes the payload through until its last beat. The output carries data, keep, valid, ready, last and user signals.

The data path is one byte wide. The keep signal is one lane wide, and the payload keep is passed through during the payload phase. A busy flag is high while a frame is in flight. The payload error flag travels with each payload beat, so an error marked on the final payload beat shows up on the final output beat. Preamble, FCS, padding and wider data paths are handled elsewhere.

Top module: `eth_hdr_prepend`

## Requirements
- R1: While rst_ni is low, hdr_ready_o, pay_ready_o, out_valid_o and busy_o are all low. In the first cycle after reset is released, hdr_ready_o rises and busy_o stays low.
- R2: hdr_ready_o is high exactly when no frame is in flight. A header is taken on a cycle where hdr_valid_i and hdr_ready_o are both high, and busy_o is high from the next cycle onward.
- R3: After a header is taken, the first 14 output bytes are, in order: the destination MAC from its bits 47:40 down to 7:0, then the source MAC in the same order, then EtherType bits 15:8 and then 7:0.
- R4: pay_ready_o stays low until all 14 header bytes have been transferred. After that it equals out_ready_i until the payload's last beat is transferred.
- R5: Payload bytes come out after the header unchanged and in order. out_last_o is high only on the output beat that carries the payload beat marked pay_last_i.
- R6: out_user_o is low on every header byte and equals pay_user_i on payload beats. A frame whose final payload beat has pay_user_i high therefore ends with out_user_o high.
- R7: busy_o is high from the cycle after a header is taken until the output beat with out_last_o is transferred. It is low in the next cycle.
- R8: With a header waiting, the next header is taken in the cycle right after the previous frame's last output transfer. The two frames come out whole, in order, with no bytes lost or merged.
- R9: While out_valid_o is high and out_ready_i is low, out_valid_o stays high and out_data_o and out_last_o hold their values into the next cycle.
- R10: A payload of one byte gives a 15-byte frame, with out_last_o high on the fifteenth byte.
- R11: out_keep_o is all ones on header bytes and equals pay_keep_i on payload beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdr_valid_i | input | 1 | Header fields valid |
| hdr_ready_o | output | 1 | Header can be taken |
| hdr_dst_i | input | 48 | Destination MAC address |
| hdr_src_i | input | 48 | Source MAC address |
| hdr_type_i | input | 16 | EtherType |
| pay_data_i | input | DATA_W | Payload byte |
| pay_keep_i | input | KEEP_W | Payload keep |
| pay_valid_i | input | 1 | Payload beat valid |
| pay_ready_o | output | 1 | Payload beat accepted |
| pay_last_i | input | 1 | Last payload beat |
| pay_user_i | input | 1 | Payload error flag |
| out_data_o | output | DATA_W | Output byte |
| out_keep_o | output | KEEP_W | Output keep |
| out_valid_o | output | 1 | Output beat valid |
| out_ready_i | input | 1 | Downstream ready |
| out_last_o | output | 1 | Last output beat |
| out_user_o | output | 1 | Output error flag |
| busy_o | output | 1 | Frame in flight |

## Verification
Only state changes happen at a clock edge. Taking a header moves the block to the header phase at the next edge, so busy_o and the first header byte appear in the cycle after the handshake. Each header or payload transfer takes effect at the edge that ends its cycle, and the state returns to idle at the edge that completes the last transfer. The output handshake signals and pay_ready_o are combinational from the registered phase and the current inputs. The bench therefore drives all inputs at the falling edge and samples all outputs 1 ns later, within the same cycle. It keeps a shadow phase of its own that is updated from the handshakes it has observed, and compares busy_o, hdr_ready_o and pay_ready_o with that shadow phase in every cycle.

// File: rtl/eth_prepend_pkg.sv
package eth_prepend_pkg;
  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_IDLE = 2'd1,
    ST_HDR  = 2'd2,
    ST_PAY  = 2'd3
  } prep_state_e;

  localparam int MAC_W  = 48;
  localparam int TYPE_W = 16;
endpackage

// File: rtl/eth_prepend_hdr_reg.sv
module eth_prepend_hdr_reg
  import eth_prepend_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HDR_W  = 2 * MAC_W + TYPE_W,
  parameter int NB     = HDR_W / DATA_W,
  parameter int CNT_W  = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MAC_W-1:0]  dst_i,
  input  logic [MAC_W-1:0]  src_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [CNT_W-1:0]  idx_i,
  output logic [DATA_W-1:0] byte_o
);
  logic [HDR_W-1:0]  hdr_q;
  logic [DATA_W-1:0] lane [NB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hdr_q <= '0;
    else if (load_i) hdr_q <= {dst_i, src_i, type_i};
  end

  // lane 0 is the first byte on the wire: most significant byte of dst
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lane[g] = hdr_q[HDR_W-1-g*DATA_W -: DATA_W];
  end

  always_comb begin
    byte_o = '0;
    for (int k = 0; k < NB; k++) begin
      if (idx_i == CNT_W'(k)) byte_o = lane[k];
    end
  end
endmodule

// File: rtl/eth_prepend_ctl.sv
module eth_prepend_ctl
  import eth_prepend_pkg::*;
#(
  parameter int NB    = 14,
  parameter int CNT_W = $clog2(NB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_valid_i,
  input  logic             out_ready_i,
  input  logic             pay_valid_i,
  input  logic             pay_last_i,
  output prep_state_e      state_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             load_o,
  output logic             hdr_ready_o,
  output logic             busy_o
);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NB - 1);

  prep_state_e      state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign hdr_ready_o = (state_q == ST_IDLE);
  assign load_o      = hdr_ready_o & hdr_valid_i;
  assign busy_o      = (state_q == ST_HDR) || (state_q == ST_PAY);
  assign state_o     = state_q;
  assign cnt_o       = cnt_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_OFF:  state_d = ST_IDLE;
      ST_IDLE: if (load_o) begin
        state_d = ST_HDR;
        cnt_d   = '0;
      end
      ST_HDR:  if (out_ready_i) begin
        if (cnt_q == CNT_LAST) begin
          state_d = ST_PAY;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_PAY:  if (pay_valid_i && out_ready_i && pay_last_i) state_d = ST_IDLE;
      default: state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end
endmodule

// File: rtl/eth_prepend_mux.sv
module eth_prepend_mux
  import eth_prepend_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int KEEP_W = DATA_W / 8
) (
  input  prep_state_e       state_i,
  input  logic [DATA_W-1:0] hdr_byte_i,
  input  logic [DATA_W-1:0] pay_data_i,
  input  logic [KEEP_W-1:0] pay_keep_i,
  input  logic              pay_valid_i,
  input  logic              pay_last_i,
  input  logic              pay_user_i,
  input  logic              out_ready_i,
  output logic              pay_ready_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic [KEEP_W-1:0] out_keep_o,
  output logic              out_valid_o,
  output logic              out_last_o,
  output logic              out_user_o
);
  always_comb begin
    pay_ready_o = 1'b0;
    out_data_o  = '0;
    out_keep_o  = '0;
    out_valid_o = 1'b0;
    out_last_o  = 1'b0;
    out_user_o  = 1'b0;
    unique case (state_i)
      ST_HDR: begin
        out_data_o  = hdr_byte_i;
        out_keep_o  = '1;
        out_valid_o = 1'b1;
      end
      ST_PAY: begin
        pay_ready_o = out_ready_i;
        out_data_o  = pay_data_i;
        out_keep_o  = pay_keep_i;
        out_valid_o = pay_valid_i;
        out_last_o  = pay_last_i;
        out_user_o  = pay_user_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/eth_hdr_prepend.sv
module eth_hdr_prepend
  import eth_prepend_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int KEEP_W = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hdr_valid_i,
  output logic              hdr_ready_o,
  input  logic [MAC_W-1:0]  hdr_dst_i,
  input  logic [MAC_W-1:0]  hdr_src_i,
  input  logic [TYPE_W-1:0] hdr_type_i,
  input  logic [DATA_W-1:0] pay_data_i,
  input  logic [KEEP_W-1:0] pay_keep_i,
  input  logic              pay_valid_i,
  output logic              pay_ready_o,
  input  logic              pay_last_i,
  input  logic              pay_user_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic [KEEP_W-1:0] out_keep_o,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              out_last_o,
  output logic              out_user_o,
  output logic              busy_o
);
  localparam int HDR_W = 2 * MAC_W + TYPE_W;
  localparam int NB    = HDR_W / DATA_W;
  localparam int CNT_W = $clog2(NB);

  prep_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             load;
  logic [DATA_W-1:0] hdr_byte;

  eth_prepend_ctl #(.NB(NB), .CNT_W(CNT_W)) u_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_valid_i (hdr_valid_i),
    .out_ready_i (out_ready_i),
    .pay_valid_i (pay_valid_i),
    .pay_last_i  (pay_last_i),
    .state_o     (state),
    .cnt_o       (cnt),
    .load_o      (load),
    .hdr_ready_o (hdr_ready_o),
    .busy_o      (busy_o)
  );

  eth_prepend_hdr_reg #(.DATA_W(DATA_W), .HDR_W(HDR_W), .NB(NB), .CNT_W(CNT_W)) u_hdr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .dst_i  (hdr_dst_i),
    .src_i  (hdr_src_i),
    .type_i (hdr_type_i),
    .idx_i  (cnt),
    .byte_o (hdr_byte)
  );

  eth_prepend_mux #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_mux (
    .state_i     (state),
    .hdr_byte_i  (hdr_byte),
    .pay_data_i  (pay_data_i),
    .pay_keep_i  (pay_keep_i),
    .pay_valid_i (pay_valid_i),
    .pay_last_i  (pay_last_i),
    .pay_user_i  (pay_user_i),
    .out_ready_i (out_ready_i),
    .pay_ready_o (pay_ready_o),
    .out_data_o  (out_data_o),
    .out_keep_o  (out_keep_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .out_user_o  (out_user_o)
  );
endmodule

// File: rtl/eth_hdr_prepend_chk.sv
module eth_hdr_prepend_chk #(
  parameter int DATA_W = 8,
  parameter int KEEP_W = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hdr_valid_i,
  input logic              hdr_ready_o,
  input logic              pay_valid_i,
  input logic              pay_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic              out_last_o,
  input logic              out_user_o,
  input logic [DATA_W-1:0] out_data_o,
  input logic [KEEP_W-1:0] out_keep_o,
  input logic              busy_o
);
  // R1
  always_comb begin
    if (!rst_ni) begin
      rst_quiet_chk: assert (!hdr_ready_o && !pay_ready_o && !out_valid_o && !busy_o);
    end
  end

  // R2
  idle_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hdr_ready_o && busy_o));

  // R2
  hdr_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdr_valid_i && hdr_ready_o |=> busy_o && out_valid_o && !pay_ready_o);

  // R4
  pay_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pay_ready_o |-> out_ready_i && busy_o);

  // R6
  hdr_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !pay_ready_o |-> !out_user_o && !out_last_o && (out_keep_o == '1));

  // R7
  end_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !busy_o && hdr_ready_o);

  // R9
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));
endmodule

bind eth_hdr_prepend eth_hdr_prepend_chk #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .hdr_valid_i (hdr_valid_i),
  .hdr_ready_o (hdr_ready_o),
  .pay_valid_i (pay_valid_i),
  .pay_ready_o (pay_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_last_o  (out_last_o),
  .out_user_o  (out_user_o),
  .out_data_o  (out_data_o),
  .out_keep_o  (out_keep_o),
  .busy_o      (busy_o)
);

// File: tb/eth_hdr_prepend_test.sv
`timescale 1ns/1ps
module eth_hdr_prepend_test;
  localparam int NBH = 14;
  localparam int MAXB = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hdr_valid_i = 1'b0;
  logic        hdr_ready_o;
  logic [47:0] hdr_dst_i = '0;
  logic [47:0] hdr_src_i = '0;
  logic [15:0] hdr_type_i = '0;
  logic [7:0]  pay_data_i = '0;
  logic [0:0]  pay_keep_i = 1'b1;
  logic        pay_valid_i = 1'b0;
  logic        pay_ready_o;
  logic        pay_last_i = 1'b0;
  logic        pay_user_i = 1'b0;
  logic [7:0]  out_data_o;
  logic [0:0]  out_keep_o;
  logic        out_valid_o;
  logic        out_ready_i = 1'b0;
  logic        out_last_o;
  logic        out_user_o;
  logic        busy_o;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk_i = ~clk_i;

  eth_hdr_prepend uut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .hdr_valid_i(hdr_valid_i), .hdr_ready_o(hdr_ready_o),
    .hdr_dst_i(hdr_dst_i), .hdr_src_i(hdr_src_i), .hdr_type_i(hdr_type_i),
    .pay_data_i(pay_data_i), .pay_keep_i(pay_keep_i), .pay_valid_i(pay_valid_i),
    .pay_ready_o(pay_ready_o), .pay_last_i(pay_last_i), .pay_user_i(pay_user_i),
    .out_data_o(out_data_o), .out_keep_o(out_keep_o), .out_valid_o(out_valid_o),
    .out_ready_i(out_ready_i), .out_last_o(out_last_o), .out_user_o(out_user_o),
    .busy_o(busy_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [111:0] hdr_of(input int f);
    return {48'hD0D1D2D3D4D5 + 48'(f), 48'h5A5152535455, 16'h0800 + 16'(f)};
  endfunction

  function automatic logic [7:0] pay_of(input int f, input int i);
    return 8'(f * 64 + i + 3);
  endfunction

  // nf frames of len payload bytes; flags: frame 0 errored, source stalls, sink stalls
  task automatic run(input int nf, input int len, input bit user0, input bit sst, input bit kst);
    logic [7:0] got_d [MAXB];
    bit got_l [MAXB];
    bit got_u [MAXB];
    int total = nf * (NBH + len);
    int got = 0, hdr_f = 0, pay_f = 0, pay_i = 0, hsent = 0, cyc = 0;
    int acc_cyc [2];
    int end_cyc [2];
    int bad_busy = 0, bad_hrdy = 0, bad_prdy = 0, bad_hold = 0, bad_keep = 0;
    int bad_hdr = 0, bad_pay = 0, bad_last = 0, bad_user = 0;
    bit in_frame = 0, pending = 0, was_stall = 0;
    logic [7:0] held = '0;
    int fe = 0;
    acc_cyc[0] = 0; acc_cyc[1] = 0; end_cyc[0] = 0; end_cyc[1] = 0;
    while (got < total && cyc < 3000) begin
      @(negedge clk_i);
      hdr_valid_i = (hdr_f < nf);
      {hdr_dst_i, hdr_src_i, hdr_type_i} = hdr_of(hdr_f);
      pay_valid_i = pending || (pay_f < nf && !(sst && (cyc % 3 == 1)));
      pay_data_i  = pay_of(pay_f, pay_i);
      pay_last_i  = (pay_i == len - 1);
      pay_user_i  = user0 && pay_f == 0 && pay_i == len - 1;
      pay_keep_i  = 1'b1;
      out_ready_i = !(kst && (cyc % 5 < 3));
      #1;
      if (busy_o !== in_frame) bad_busy++;
      if (hdr_ready_o !== !in_frame) bad_hrdy++;
      if (pay_ready_o !== (in_frame && hsent == NBH && out_ready_i)) bad_prdy++;
      if (was_stall && (!out_valid_o || out_data_o !== held)) bad_hold++;
      was_stall = out_valid_o && !out_ready_i;
      held = out_data_o;
      if (out_valid_o && out_ready_i) begin
        if (got < MAXB) begin
          got_d[got] = out_data_o; got_l[got] = out_last_o; got_u[got] = out_user_o;
        end
        if (out_keep_o !== 1'b1) bad_keep++;
        got++;
        if (hsent < NBH) hsent++;
        if (out_last_o) begin
          in_frame = 0;
          if (fe < 2) end_cyc[fe] = cyc;
          fe++;
        end
      end
      if (hdr_valid_i && hdr_ready_o) begin
        in_frame = 1; hsent = 0;
        if (hdr_f < 2) acc_cyc[hdr_f] = cyc;
        hdr_f++;
      end
      pending = pay_valid_i && !pay_ready_o;
      if (pay_valid_i && pay_ready_o) begin
        pay_i++;
        if (pay_i == len) begin pay_i = 0; pay_f++; end
      end
      cyc++;
    end
    @(negedge clk_i);
    hdr_valid_i = 0; pay_valid_i = 0; pay_last_i = 0; pay_user_i = 0; out_ready_i = 1;
    #1;
    // R5 byte count
    chk(got == total, "R5 byte count", got, total);
    for (int f = 0; f < nf; f++) begin
      logic [111:0] h = hdr_of(f);
      for (int k = 0; k < NBH + len; k++) begin
        int p = f * (NBH + len) + k;
        if (p < got && p < MAXB) begin
          if (k < NBH) begin
            if (got_d[p] !== h[111-8*k -: 8]) bad_hdr++;
            if (got_u[p]) bad_user++;
          end else begin
            if (got_d[p] !== pay_of(f, k - NBH)) bad_pay++;
            if (got_u[p] !== (user0 && f == 0 && k == NBH + len - 1)) bad_user++;
          end
          if (got_l[p] !== (k == NBH + len - 1)) bad_last++;
        end
      end
    end
    chk(bad_hdr == 0, "R3 header bytes", bad_hdr, 0);
    chk(bad_pay == 0, "R5 payload bytes", bad_pay, 0);
    chk(bad_last == 0, len == 1 ? "R10 last on byte 15" : "R5 last position", bad_last, 0);
    chk(bad_user == 0, "R6 user flag", bad_user, 0);
    chk(bad_keep == 0, "R11 keep", bad_keep, 0);
    chk(bad_busy == 0, "R7 busy tracking", bad_busy, 0);
    chk(bad_hrdy == 0, "R2 hdr ready", bad_hrdy, 0);
    chk(bad_prdy == 0, "R4 payload ready", bad_prdy, 0);
    if (kst) chk(bad_hold == 0, "R9 stall hold", bad_hold, 0);
    if (nf == 2) chk(acc_cyc[1] == end_cyc[0] + 1, "R8 back-to-back gap", acc_cyc[1], end_cyc[0] + 1);
    chk(!busy_o && hdr_ready_o, "R7 idle after frame", busy_o, 0);
  endtask

  task automatic t_reset();
    rst_ni = 0;
    @(negedge clk_i); #1;
    chk(!hdr_ready_o && !pay_ready_o && !out_valid_o && !busy_o, "R1 in reset",
        {hdr_ready_o, pay_ready_o, out_valid_o, busy_o}, 0);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i); #1;
    chk(hdr_ready_o && !busy_o, "R1 after release", {hdr_ready_o, busy_o}, 2);
  endtask

  task automatic t_single();
    run(1, 1, 0, 0, 0);   // R10
    run(1, 6, 0, 0, 0);   // R3 R5
  endtask

  task automatic t_b2b();
    run(2, 3, 0, 0, 0);   // R8
  endtask

  task automatic t_user();
    run(2, 2, 1, 0, 0);   // R6
  endtask

  task automatic t_stall();
    run(1, 4, 0, 1, 0);   // source stalls
    run(1, 4, 0, 0, 1);   // R9 sink stalls
    run(2, 1, 1, 1, 1);   // R8 R9 both
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_b2b();
    t_user();
    t_stall();
    repeat (2) @(negedge clk_i);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule